// File: doc/BRIEF.md
# Embedded Timer Unit

This block gives a processor core three time-base driven timers that share one control register and one status register. Every timing event advances on a single-cycle tick enable that comes from the core's time base, not on every clock. The first timer is an interval down-counter with optional automatic reload. The second is a periodic timer whose period is picked from four powers of two. The third is a watchdog that escalates through three stages on successive expiries. It first arms, then raises an interrupt, and finally issues a reset request of a selectable kind.

Software writes the control register and the interval reload value through a simple write port. It reads control, status and the live interval count through a combinational read port. Status event bits are cleared by writing ones to them. The watchdog's reset-kind field in status is not writable and keeps its value until the block is reset. The three interrupt lines are levels: each is a status bit gated by its enable bit. The reset requests are one-cycle pulses. The block only asks for a reset; carrying it out belongs to the surrounding logic.

Top module: `embedded_timer_unit`

## Requirements
- R1: After reset, control, status and the interval count all read zero, and every interrupt and reset-request output is low.
- R2: Register select codes are 0 control, 1 status, 2 interval value, and 3 reads as zero. Only control bits [31:22] are stored; bits [21:0] read zero.
- R3: A write to select 2 loads both the reload value and the count. While control bit 26 is set and the reload value exceeds 1, each tick lowers the count by one. On the tick that finds the count at 1, status bit 27 is set. `irq_interval` equals status bit 27 AND control bit 26.
- R4: On interval expiry with control bit 22 set, the count returns to the reload value and keeps running. With bit 22 clear, the count goes to 0 and no further expiry happens until the next load.
- R5: With a reload value of 0 or 1, or with control bit 26 clear, ticks leave the count unchanged and never set status bit 27.
- R6: The periodic timer fires on every tick whose 1-based index since reset is a multiple of 2^(FIXED_EXP0 + s*EXP_STEP), with s = control[25:24]. Each firing sets status bit 26, and `irq_fixed` equals status bit 26 AND control bit 23.
- R7: Writing to select 1 clears each of status bits 31, 30, 27 and 26 whose data bit is 1. Bits written as 0 are left as they are.
- R8: The watchdog expires on every tick whose 1-based index is a multiple of 2^(WDOG_EXP0 + w*EXP_STEP), with w = control[31:30]. On expiry, if status bit 31 is clear it is set; if status[31:30] is 2'b10, bit 30 is set. `irq_watchdog` equals status bit 30 AND control bit 27.
- R9: A watchdog expiry with status[31:30] = 2'b11 copies control[29:28] into status[29:28] if that field is zero. In the next cycle it issues a one-cycle pulse on `rst_req_core` for kind 1, `rst_req_chip` for kind 2, or `rst_req_system` for kind 3, and no pulse for kind 0.
- R10: Status[29:28], once non-zero, is unaffected by writes and by later expiries until reset.
- R11: At most one reset-request output is high in any cycle, and none is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base tick enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| irq_interval | output | 1 | Interval timer interrupt level |
| irq_fixed | output | 1 | Periodic timer interrupt level |
| irq_watchdog | output | 1 | Watchdog interrupt level |
| rst_req_core | output | 1 | Core reset request pulse |
| rst_req_chip | output | 1 | Chip reset request pulse |
| rst_req_system | output | 1 | System reset request pulse |

## Verification
The interval timer is driven with a large reload under auto-reload, with a one-shot load, and with reloads of 0 and 1 plus a disabled enable. These patterns separate correct reload, stop and gating behaviour from an off-by-one count or a counter that wraps past zero. The periodic timer runs at two different period selects, with its interrupt enable set and clear, so a wrong exponent mapping or a missing gate on the interrupt shows up. The watchdog is run through all three stages twice, with reset kinds chip then system and then with kind 0. This tells apart a pulse on the wrong line, a reset field that is overwritten or cleared, and a pulse issued for kind zero.

// File: rtl/etu_pkg.sv
// Shared constants for the embedded timer unit: register selects and the
// bit positions of the control and status fields. Assumes 32-bit registers.
package etu_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IVAL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int REG_W = 32;

    // Control field positions
    localparam int CT_WSEL_LO = 30;  // watchdog period select [31:30]
    localparam int CT_WRST_LO = 28;  // watchdog reset kind [29:28]
    localparam int CT_WIE     = 27;  // watchdog interrupt enable
    localparam int CT_IIE     = 26;  // interval interrupt / run enable
    localparam int CT_FSEL_LO = 24;  // periodic period select [25:24]
    localparam int CT_FIE     = 23;  // periodic interrupt enable
    localparam int CT_ARE     = 22;  // interval auto-reload enable

    // Status field positions
    localparam int ST_WNEXT   = 31;  // watchdog armed
    localparam int ST_WIRQ    = 30;  // watchdog interrupt stage
    localparam int ST_WRST_LO = 28;  // latched reset kind [29:28]
    localparam int ST_IVAL    = 27;  // interval expired
    localparam int ST_FIX     = 26;  // periodic fired

    localparam logic [REG_W-1:0] CTRL_MASK = 32'hFFC0_0000;
    localparam logic [REG_W-1:0] W1C_MASK  = 32'hCC00_0000;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_CORE   = 2'd1,
        RK_CHIP   = 2'd2,
        RK_SYSTEM = 2'd3
    } reset_kind_e;

endpackage

// File: rtl/etu_prescaler.sv
// Free-running tick counter shared by the periodic timer and the watchdog.
// Each produces a one-cycle fire strobe on the tick that completes a period
// of 2^(EXP0 + sel*EXP_STEP) ticks. Assumes the tick is a single-cycle enable.
module etu_prescaler #(
    parameter int FIXED_EXP0 = 9,
    parameter int WDOG_EXP0  = 17,
    parameter int EXP_STEP   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] fix_sel,
    input  logic [1:0] wdog_sel,
    output logic       fix_fire,
    output logic       wdog_fire
);
    localparam int MAX_EXP0 = (FIXED_EXP0 > WDOG_EXP0) ? FIXED_EXP0 : WDOG_EXP0;
    localparam int FREE_W   = MAX_EXP0 + 3 * EXP_STEP;
    localparam int N_SEL    = 4;

    logic [FREE_W-1:0] free_q;
    logic [FREE_W-1:0] fix_mask  [N_SEL];
    logic [FREE_W-1:0] wdog_mask [N_SEL];

    // One low-bit mask per period select, for both timers
    for (genvar g = 0; g < N_SEL; g++) begin : g_mask
        assign fix_mask[g]  = {FREE_W{1'b1}} >> (FREE_W - (FIXED_EXP0 + g * EXP_STEP));
        assign wdog_mask[g] = {FREE_W{1'b1}} >> (FREE_W - (WDOG_EXP0 + g * EXP_STEP));
    end

    // Count ticks since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '0;
        end else if (tick) begin
            free_q <= free_q + FREE_W'(1);
        end
    end

    // Fire when the selected low bits are about to roll over
    always_comb begin
        fix_fire  = tick && ((free_q & fix_mask[fix_sel]) == fix_mask[fix_sel]);
        wdog_fire = tick && ((free_q & wdog_mask[wdog_sel]) == wdog_mask[wdog_sel]);
    end

endmodule

// File: rtl/etu_interval.sv
// Interval down-counter with reload. A load sets reload and count and arms
// the counter. It runs only while enabled and the reload value exceeds 1.
// The expire strobe is combinational and lands on the tick that finds the
// count at 1. Assumes IVAL_W <= 32.
module etu_interval #(
    parameter int IVAL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [IVAL_W-1:0] load_val,
    input  logic              run_en,
    input  logic              auto_reload,
    output logic [IVAL_W-1:0] count,
    output logic              expire
);
    logic [IVAL_W-1:0] reload_q;
    logic [IVAL_W-1:0] cnt_q;
    logic              armed_q;
    logic              running;

    // Running condition and expiry strobe
    always_comb begin
        running = armed_q && run_en && (reload_q > IVAL_W'(1));
        expire  = tick && running && (cnt_q == IVAL_W'(1));
        count   = cnt_q;
    end

    // Load, count down, reload or stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            armed_q  <= 1'b0;
        end else if (load) begin
            reload_q <= load_val;
            cnt_q    <= load_val;
            armed_q  <= 1'b1;
        end else if (tick && running) begin
            if (cnt_q == IVAL_W'(1)) begin
                if (auto_reload) begin
                    cnt_q <= reload_q;
                end else begin
                    cnt_q   <= '0;
                    armed_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - IVAL_W'(1);
            end
        end
    end

endmodule

// File: rtl/etu_watchdog.sv
// Watchdog stage decoder. On each expiry it reports which status stage to
// set from the current status bits. On the final stage it issues a
// registered one-cycle reset-request pulse of the selected kind.
module etu_watchdog
    import etu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       st_next,
    input  logic       st_irq,
    input  logic [1:0] kind,
    output logic       set_next,
    output logic       set_irq,
    output logic       final_hit,
    output logic       req_core,
    output logic       req_chip,
    output logic       req_system
);
    reset_kind_e kind_e;

    // Stage decode for the current expiry
    always_comb begin
        kind_e    = reset_kind_e'(kind);
        set_next  = fire && !st_next;
        set_irq   = fire && st_next && !st_irq;
        final_hit = fire && st_next && st_irq;
    end

    // Reset-request pulses, high for the cycle after the final expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_core   <= 1'b0;
            req_chip   <= 1'b0;
            req_system <= 1'b0;
        end else begin
            req_core   <= final_hit && (kind_e == RK_CORE);
            req_chip   <= final_hit && (kind_e == RK_CHIP);
            req_system <= final_hit && (kind_e == RK_SYSTEM);
        end
    end

endmodule

// File: rtl/embedded_timer_unit.sv
// Embedded timer unit top: holds the shared control and status registers.
// It connects the prescaler, the interval timer and the watchdog decoder,
// and drives the interrupt levels and the read port. Assumes single-cycle
// writes and a tick enable from the time base.
module embedded_timer_unit
    import etu_pkg::*;
#(
    parameter int FIXED_EXP0 = 9,
    parameter int WDOG_EXP0  = 17,
    parameter int EXP_STEP   = 4,
    parameter int IVAL_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        irq_interval,
    output logic        irq_fixed,
    output logic        irq_watchdog,
    output logic        rst_req_core,
    output logic        rst_req_chip,
    output logic        rst_req_system
);
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  stat_q;
    logic [REG_W-1:0]  stat_d;
    logic [IVAL_W-1:0] ival_count;
    logic              ival_load;
    logic              ival_expire;
    logic              fix_fire;
    logic              wdog_fire;
    logic              wd_set_next;
    logic              wd_set_irq;
    logic              wd_final;
    reg_sel_e          wsel;
    reg_sel_e          rsel;

    assign wsel      = reg_sel_e'(wr_sel);
    assign rsel      = reg_sel_e'(rd_sel);
    assign ival_load = wr_en && (wsel == SEL_IVAL);

    etu_prescaler #(
        .FIXED_EXP0 (FIXED_EXP0),
        .WDOG_EXP0  (WDOG_EXP0),
        .EXP_STEP   (EXP_STEP)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fix_sel   (ctrl_q[CT_FSEL_LO +: 2]),
        .wdog_sel  (ctrl_q[CT_WSEL_LO +: 2]),
        .fix_fire  (fix_fire),
        .wdog_fire (wdog_fire)
    );

    etu_interval #(
        .IVAL_W (IVAL_W)
    ) u_interval (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load        (ival_load),
        .load_val    (wr_data[IVAL_W-1:0]),
        .run_en      (ctrl_q[CT_IIE]),
        .auto_reload (ctrl_q[CT_ARE]),
        .count       (ival_count),
        .expire      (ival_expire)
    );

    etu_watchdog u_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (wdog_fire),
        .st_next    (stat_q[ST_WNEXT]),
        .st_irq     (stat_q[ST_WIRQ]),
        .kind       (ctrl_q[CT_WRST_LO +: 2]),
        .set_next   (wd_set_next),
        .set_irq    (wd_set_irq),
        .final_hit  (wd_final),
        .req_core   (rst_req_core),
        .req_chip   (rst_req_chip),
        .req_system (rst_req_system)
    );

    // Control register: only the defined fields are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (wsel == SEL_CTRL)) begin
            ctrl_q <= wr_data & CTRL_MASK;
        end
    end

    // Next status: write-one-to-clear first, then events set bits
    always_comb begin
        stat_d = stat_q;
        if (wr_en && (wsel == SEL_STAT)) begin
            stat_d = stat_d & ~(wr_data & W1C_MASK);
        end
        if (ival_expire) stat_d[ST_IVAL]  = 1'b1;
        if (fix_fire)    stat_d[ST_FIX]   = 1'b1;
        if (wd_set_next) stat_d[ST_WNEXT] = 1'b1;
        if (wd_set_irq)  stat_d[ST_WIRQ]  = 1'b1;
        if (wd_final && (stat_q[ST_WRST_LO +: 2] == 2'b00)) begin
            stat_d[ST_WRST_LO +: 2] = ctrl_q[CT_WRST_LO +: 2];
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    // Interrupt levels: status event gated by its enable
    always_comb begin
        irq_interval = stat_q[ST_IVAL] && ctrl_q[CT_IIE];
        irq_fixed    = stat_q[ST_FIX]  && ctrl_q[CT_FIE];
        irq_watchdog = stat_q[ST_WIRQ] && ctrl_q[CT_WIE];
    end

    // Combinational read mux
    always_comb begin
        unique case (rsel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_STAT: rd_data = stat_q;
            SEL_IVAL: rd_data = 32'(ival_count);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/etu_checker.sv
// Temporal checks for the embedded timer unit, bound to the top module.
// Sees the upper status bits, the tick and the reset-request pulses.
module etu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [5:0] stat_hi,
    input logic       req_core,
    input logic       req_chip,
    input logic       req_system
);
    // stat_hi[5]=bit31, [4]=bit30, [3:2]=bits29:28, [1]=bit27, [0]=bit26
    logic [2:0] reqs;
    assign reqs = {req_system, req_chip, req_core};

    p_ival_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_hi[1]) |-> $past(tick));

    p_fixed_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_hi[0]) |-> $past(tick));

    p_irq_after_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_hi[4]) |-> $past(stat_hi[5]));

    p_pulse_from_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|reqs) |-> ($past(stat_hi[5:4]) == 2'b11));

    p_field_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hi[3:2] != 2'b00) |=> $stable(stat_hi[3:2]));

    p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|reqs) |=> !(|reqs));

endmodule

bind embedded_timer_unit etu_checker u_etu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .stat_hi    (stat_q[31:26]),
    .req_core   (rst_req_core),
    .req_chip   (rst_req_chip),
    .req_system (rst_req_system)
);

// File: tb/embedded_timer_unit_bench.sv
// Directed bench: short periods (periodic 4/8/16/32, watchdog 16/32/64/128).
module embedded_timer_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_interval, irq_fixed, irq_watchdog;
    logic        rst_req_core, rst_req_chip, rst_req_system;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    embedded_timer_unit #(
        .FIXED_EXP0 (2),
        .WDOG_EXP0  (4),
        .EXP_STEP   (1),
        .IVAL_W     (32)
    ) u_embedded_timer_unit (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .rd_sel (rd_sel), .rd_data (rd_data),
        .irq_interval (irq_interval), .irq_fixed (irq_fixed),
        .irq_watchdog (irq_watchdog), .rst_req_core (rst_req_core),
        .rst_req_chip (rst_req_chip), .rst_req_system (rst_req_system)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    function automatic logic [31:0] pulses();
        return {29'd0, rst_req_system, rst_req_chip, rst_req_core};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 count", v, 0);
        chk("R1 outputs", {26'd0, irq_interval, irq_fixed, irq_watchdog,
                           rst_req_core, rst_req_chip, rst_req_system}, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2 ctrl mask", v, 32'hFFC0_0000);
        rd(2'd3, v); chk("R2 select 3", v, 0);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2 ctrl clear", v, 0);
    endtask

    task automatic t_interval_auto();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h0440_0000);
        wr(2'd2, 32'd5);
        rd(2'd2, v); chk("R3 load", v, 5);
        ticks(4);
        rd(2'd2, v); chk("R3 count down", v, 1);
        rd(2'd1, v); chk("R3 not yet", v & 32'h0800_0000, 0);
        tick_once();
        rd(2'd1, v); chk("R3 expired", v & 32'h0800_0000, 32'h0800_0000);
        chk("R3 irq", {31'd0, irq_interval}, 1);
        rd(2'd2, v); chk("R4 reloaded", v, 5);
        wr(2'd1, 32'h0800_0000);
        rd(2'd1, v); chk("R7 w1c", v & 32'h0800_0000, 0);
        chk("R7 irq cleared", {31'd0, irq_interval}, 0);
        ticks(4);
        rd(2'd1, v); chk("R4 second period early", v & 32'h0800_0000, 0);
        tick_once();
        rd(2'd1, v); chk("R4 second expiry", v & 32'h0800_0000, 32'h0800_0000);
    endtask

    task automatic t_interval_oneshot();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h0400_0000);
        wr(2'd2, 32'd3);
        ticks(3);
        rd(2'd1, v); chk("R4 oneshot expiry", v & 32'h0800_0000, 32'h0800_0000);
        rd(2'd2, v); chk("R4 stopped count", v, 0);
        wr(2'd1, 32'h0800_0000);
        ticks(8);
        rd(2'd1, v); chk("R4 no re-expiry", v & 32'h0800_0000, 0);
        rd(2'd2, v); chk("R4 count stays", v, 0);
    endtask

    task automatic t_interval_gated();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h0400_0000);
        wr(2'd2, 32'd1);
        ticks(4);
        rd(2'd2, v); chk("R5 reload 1 holds", v, 1);
        rd(2'd1, v); chk("R5 reload 1 no expiry", v & 32'h0800_0000, 0);
        wr(2'd2, 32'd0);
        ticks(3);
        rd(2'd2, v); chk("R5 reload 0 holds", v, 0);
        rd(2'd1, v); chk("R5 reload 0 no expiry", v & 32'h0800_0000, 0);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd6);
        ticks(3);
        rd(2'd2, v); chk("R5 disabled holds", v, 6);
        wr(2'd0, 32'h0400_0000);
        ticks(2);
        rd(2'd2, v); chk("R3 resumes", v, 4);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h0180_0000);          // select 1 (8 ticks), irq enabled
        ticks(7);
        rd(2'd1, v); chk("R6 sel1 early", v & 32'h0400_0000, 0);
        tick_once();
        rd(2'd1, v); chk("R6 sel1 fire", v & 32'h0400_0000, 32'h0400_0000);
        chk("R6 irq", {31'd0, irq_fixed}, 1);
        wr(2'd1, 32'h0400_0000);
        ticks(7);
        rd(2'd1, v); chk("R6 sel1 second early", v & 32'h0400_0000, 0);
        tick_once();
        rd(2'd1, v); chk("R6 sel1 second fire", v & 32'h0400_0000, 32'h0400_0000);
        do_reset();
        wr(2'd0, 32'h0200_0000);          // select 2 (16 ticks), irq disabled
        ticks(15);
        rd(2'd1, v); chk("R6 sel2 early", v & 32'h0400_0000, 0);
        tick_once();
        rd(2'd1, v); chk("R6 sel2 fire", v & 32'h0400_0000, 32'h0400_0000);
        chk("R6 irq gated", {31'd0, irq_fixed}, 0);
    endtask

    task automatic t_watchdog();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h2800_0000);          // period 16, kind chip, irq enabled
        ticks(15);
        rd(2'd1, v); chk("R8 before expiry", v & 32'hF000_0000, 0);
        tick_once();
        rd(2'd1, v); chk("R8 armed", v & 32'hF000_0000, 32'h8000_0000);
        ticks(16);
        rd(2'd1, v); chk("R8 irq stage", v & 32'hF000_0000, 32'hC000_0000);
        chk("R8 irq out", {31'd0, irq_watchdog}, 1);
        ticks(15);
        chk("R9 no early pulse", pulses(), 0);
        tick_once();
        chk("R9 chip pulse", pulses(), 32'd2);
        rd(2'd1, v); chk("R9 field latched", v & 32'hF000_0000, 32'hE000_0000);
        @(negedge clk);
        chk("R11 pulse one cycle", pulses(), 0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10 field survives w1c", v & 32'hF000_0000, 32'h2000_0000);
        wr(2'd0, 32'h3800_0000);          // kind system
        ticks(47);
        chk("R9 no pulse before third stage", pulses(), 0);
        tick_once();
        chk("R9 system pulse", pulses(), 32'd4);
        rd(2'd1, v); chk("R10 field held", v & 32'h3000_0000, 32'h2000_0000);
        do_reset();
        rd(2'd1, v); chk("R10 cleared by reset", v, 0);
        wr(2'd0, 32'h4000_0000);          // period 32, kind none, irq disabled
        ticks(95);
        chk("R9 kind 0 early", pulses(), 0);
        tick_once();
        chk("R9 kind 0 no pulse", pulses(), 0);
        @(negedge clk);
        chk("R9 kind 0 still none", pulses(), 0);
        rd(2'd1, v); chk("R9 kind 0 status", v & 32'hF000_0000, 32'hC000_0000);
        chk("R8 irq gated", {31'd0, irq_watchdog}, 0);
    endtask

    initial begin
        t_reset();
        t_ctrl();
        t_interval_auto();
        t_interval_oneshot();
        t_interval_gated();
        t_fixed();
        t_watchdog();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule